// File: doc/BRIEF.md
# Flash Sector Lock State Controller

This block holds the protection state of every erase sector of a flash-style memory and decides, sector by sector, whether program and erase may proceed. Each sector keeps two stored bits, a lock-down flag and a lock flag. Together with the write-protect pin they form a three-bit effective state written here as [wp ld lk]. Lock, unlock and lock-down strobes address one sector at a time. Program and erase are allowed only while the effective lock bit is clear.

The lock-down flag is sticky. No command clears it; only reset does. While write-protect is low, a sector with lock-down set is frozen: it reads as locked and ignores every command. Raising write-protect lifts that freeze, and the sector can then be unlocked and relocked freely. When write-protect falls again the sector reads locked at once, and its stored lock bit is forced back to 1.

A combinational status port returns the two stored-state bits of any sector in the same cycle. A program/erase request is granted in the same cycle when its sector is writable. A request to a blocked sector is refused and raises a protection-error pulse on the following cycle.

Top module: `sector_lock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every sector reads status {ld,lk} = 2'b01 (locked, lock-down clear) and its write-enable bit is 0.
- R2: Bit i of wr_en_o is 1 exactly when sector i is in effective state [000], [100] or [110]. It is 0 in [001], [101], [011] and [111].
- R3: A lock strobe sets the addressed sector's lock bit at the next clock edge: [000]→[001], [100]→[101], [110]→[111]. It has no effect in any other state.
- R4: An unlock strobe clears the addressed sector's lock bit at the next clock edge: [001]→[000], [101]→[100], [111]→[110]. It has no effect in [011] or on a sector that is already unlocked.
- R5: A lock-down strobe sets both the lock-down bit and the lock bit of the addressed sector. With write-protect low the sector goes to [011]; with it high the sector goes to [111].
- R6: In [011] (write-protect low, lock-down set) lock, unlock and lock-down strobes all leave the sector unchanged.
- R7: With write-protect high, a sector with lock-down set moves between [111] and [110] under unlock and lock, and is writable in [110].
- R8: The lock-down bit is cleared only by reset. When write-protect falls, any sector with lock-down set reads status 2'b11 in the same cycle. After one clock edge with write-protect low, its stored lock bit is 1, so it still reads 2'b11 once write-protect rises again.
- R9: rd_status_o returns {lock-down, lock} of the sector selected by rd_sect_i in the same cycle, with bit 1 = lock-down and bit 0 = lock. The lock bit reads 1 whenever write-protect is low and lock-down is set.
- R10: pe_grant_o is 1 in the same cycle as pe_req_i when sector pe_sect_i is writable, and 0 otherwise. A request to a blocked sector makes prot_err_o 1 for exactly the next cycle; a granted request or no request gives 0.
- R11: A strobe affects only the sector selected by cmd_sect_i. When several strobes are high together, lock-down wins over lock, and lock wins over unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wp_i | input | 1 | Write-protect pin level |
| cmd_sect_i | input | SECT_W | Sector addressed by the command strobes |
| lock_i | input | 1 | Lock strobe |
| unlock_i | input | 1 | Unlock strobe |
| lockdown_i | input | 1 | Lock-down strobe |
| rd_sect_i | input | SECT_W | Sector selected for the status read |
| rd_status_o | output | 2 | {lock-down, lock} of the selected sector |
| wr_en_o | output | N_SECT | Per-sector program/erase permission |
| pe_req_i | input | 1 | Program/erase request |
| pe_sect_i | input | SECT_W | Sector of the program/erase request |
| pe_grant_o | output | 1 | Request accepted, array may be written |
| prot_err_o | output | 1 | One-cycle pulse after a refused request |

## Verification
The properties assume that the write-protect pin and the strobes are synchronous to clk_i and stable around its rising edge. They also assume that every sector index is below N_SECT, so that no strobe or request falls outside the table. The stimulus changes all inputs on the falling edge only. It draws indices from the valid range, and it raises strobes alone and in combination so that the priority order is exercised. It also toggles write-protect both between commands and while commands are in flight, and it pulses reset in the middle of the run to confirm that only reset clears the lock-down flags.

// File: rtl/sl_pkg.sv
package sl_pkg;
  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2,
    CMD_LDOWN  = 2'd3
  } sl_cmd_e;

  typedef struct packed {
    logic ld;
    logic lk;
  } sl_bits_t;

  localparam sl_bits_t SL_RESET = '{ld: 1'b0, lk: 1'b1};
endpackage

// File: rtl/sl_cmd_decode.sv
module sl_cmd_decode
  import sl_pkg::*;
#(
  parameter int N_SECT = 8,
  parameter int SECT_W = 3
) (
  input  logic [SECT_W-1:0] sect_i,
  input  logic              lock_i,
  input  logic              unlock_i,
  input  logic              lockdown_i,
  output sl_cmd_e           cmd_o,
  output logic [N_SECT-1:0] hit_o
);
  // lock-down > lock > unlock
  always_comb begin
    if (lockdown_i)    cmd_o = CMD_LDOWN;
    else if (lock_i)   cmd_o = CMD_LOCK;
    else if (unlock_i) cmd_o = CMD_UNLOCK;
    else               cmd_o = CMD_NONE;
  end

  for (genvar g = 0; g < N_SECT; g++) begin : g_hit
    assign hit_o[g] = (int'(sect_i) == g);
  end
endmodule

// File: rtl/sl_sector_cell.sv
module sl_sector_cell
  import sl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wp_i,
  input  logic    hit_i,
  input  sl_cmd_e cmd_i,
  output logic    ld_o,
  output logic    lk_reg_o,
  output logic    eff_lk_o,
  output logic    wr_en_o
);
  sl_bits_t st_q, st_d;
  logic     frozen;

  assign frozen = st_q.ld & ~wp_i;

  always_comb begin
    st_d = st_q;
    if (hit_i) begin
      unique case (cmd_i)
        CMD_LDOWN:  begin st_d.ld = 1'b1; st_d.lk = 1'b1; end
        CMD_LOCK:   st_d.lk = 1'b1;
        CMD_UNLOCK: if (!frozen) st_d.lk = 1'b0;
        default:    ;
      endcase
    end
    if (frozen) st_d.lk = 1'b1; // pin low re-arms lock-down
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SL_RESET;
    else         st_q <= st_d;
  end

  assign ld_o     = st_q.ld;
  assign lk_reg_o = st_q.lk;
  assign eff_lk_o = st_q.lk | frozen;
  assign wr_en_o  = ~eff_lk_o;
endmodule

// File: rtl/sl_access_check.sv
module sl_access_check #(
  parameter int N_SECT = 8,
  parameter int SECT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SECT-1:0] wr_en_i,
  input  logic              pe_req_i,
  input  logic [SECT_W-1:0] pe_sect_i,
  output logic              pe_grant_o,
  output logic              prot_err_o
);
  logic in_range, err_q;

  assign in_range   = int'(pe_sect_i) < N_SECT;
  assign pe_grant_o = pe_req_i & in_range & wr_en_i[pe_sect_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= pe_req_i & ~pe_grant_o;
  end

  assign prot_err_o = err_q;
endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl
  import sl_pkg::*;
#(
  parameter int N_SECT = 8,
  parameter int SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic [SECT_W-1:0] cmd_sect_i,
  input  logic              lock_i,
  input  logic              unlock_i,
  input  logic              lockdown_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  output logic [1:0]        rd_status_o,
  output logic [N_SECT-1:0] wr_en_o,
  input  logic              pe_req_i,
  input  logic [SECT_W-1:0] pe_sect_i,
  output logic              pe_grant_o,
  output logic              prot_err_o
);
  sl_cmd_e           cmd;
  logic [N_SECT-1:0] hit, ld_vec, lk_reg_vec, eff_lk_vec;

  sl_cmd_decode #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_dec (
    .sect_i     (cmd_sect_i),
    .lock_i     (lock_i),
    .unlock_i   (unlock_i),
    .lockdown_i (lockdown_i),
    .cmd_o      (cmd),
    .hit_o      (hit)
  );

  for (genvar g = 0; g < N_SECT; g++) begin : g_sect
    sl_sector_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wp_i     (wp_i),
      .hit_i    (hit[g]),
      .cmd_i    (cmd),
      .ld_o     (ld_vec[g]),
      .lk_reg_o (lk_reg_vec[g]),
      .eff_lk_o (eff_lk_vec[g]),
      .wr_en_o  (wr_en_o[g])
    );
  end

  always_comb begin
    if (int'(rd_sect_i) < N_SECT) rd_status_o = {ld_vec[rd_sect_i], eff_lk_vec[rd_sect_i]};
    else                          rd_status_o = 2'b00;
  end

  sl_access_check #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_o),
    .pe_req_i   (pe_req_i),
    .pe_sect_i  (pe_sect_i),
    .pe_grant_o (pe_grant_o),
    .prot_err_o (prot_err_o)
  );
endmodule

// File: rtl/sl_lock_checker.sv
module sl_lock_checker #(
  parameter int N_SECT = 8,
  parameter int SECT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_i,
  input logic [N_SECT-1:0] ld_q,
  input logic [N_SECT-1:0] lk_q,
  input logic [N_SECT-1:0] wr_en_o,
  input logic [1:0]        rd_status_o,
  input logic              pe_req_i,
  input logic [SECT_W-1:0] pe_sect_i,
  input logic              pe_grant_o,
  input logic              prot_err_o
);
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (ld_q == '0 && lk_q == '1 && wr_en_o == '0));

  p_locked_down_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o & ld_q & {N_SECT{~wp_i}}) == '0);

  p_frozen_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ld_q & lk_q & {N_SECT{~wp_i}}) & ~lk_q) == '0));

  p_ld_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ld_q) & ~ld_q) == '0));

  p_ld_reads_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_i && rd_status_o[1]) |-> rd_status_o[0]);

  p_grant_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_grant_o |-> (pe_req_i && wr_en_o[pe_sect_i]));

  p_err_after_refusal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_req_i && !pe_grant_o) |=> prot_err_o);

  p_no_err_after_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_grant_o |=> !prot_err_o);
endmodule

bind sector_lock_ctrl sl_lock_checker #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wp_i        (wp_i),
  .ld_q        (ld_vec),
  .lk_q        (lk_reg_vec),
  .wr_en_o     (wr_en_o),
  .rd_status_o (rd_status_o),
  .pe_req_i    (pe_req_i),
  .pe_sect_i   (pe_sect_i),
  .pe_grant_o  (pe_grant_o),
  .prot_err_o  (prot_err_o)
);

// File: tb/sector_lock_ctrl_test.sv
`timescale 1ns/100ps
module sector_lock_ctrl_test;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic wp = 1'b0, lock = 1'b0, unlock = 1'b0, ldown = 1'b0, pe_req = 1'b0;
  logic [W-1:0] cmd_sect = '0, rd_sect = '0, pe_sect = '0;
  logic [1:0]   rd_status;
  logic [N-1:0] wr_en;
  logic         pe_grant, prot_err;

  int checks = 0, fails = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  bit m_ld[N], m_lk[N];
  bit m_err;

  always #2.5 clk = ~clk; // 200 MHz

  sector_lock_ctrl #(.N_SECT(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .cmd_sect_i(cmd_sect),
    .lock_i(lock), .unlock_i(unlock), .lockdown_i(ldown),
    .rd_sect_i(rd_sect), .rd_status_o(rd_status), .wr_en_o(wr_en),
    .pe_req_i(pe_req), .pe_sect_i(pe_sect), .pe_grant_o(pe_grant), .prot_err_o(prot_err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic bit m_blocked(int s);
    return m_lk[s] || (m_ld[s] && !wp);
  endfunction

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_ld[i] = 1'b0; m_lk[i] = 1'b1; end
      m_err = 1'b0;
    end else begin
      int s;
      bit froz;
      m_err = pe_req && m_blocked(int'(pe_sect));
      s = int'(cmd_sect);
      froz = m_ld[s] && !wp;
      if (ldown) begin m_ld[s] = 1'b1; m_lk[s] = 1'b1; end
      else if (lock) m_lk[s] = 1'b1;
      else if (unlock && !froz) m_lk[s] = 1'b0;
      for (int i = 0; i < N; i++) if (!wp && m_ld[i]) m_lk[i] = 1'b1;
    end
  end

  // per-cycle comparison, half a cycle after inputs settle
  always @(negedge clk) begin
    #2;
    if (cmp_en) begin
      logic [N-1:0] exp_we;
      int r;
      for (int i = 0; i < N; i++) exp_we[i] = !m_blocked(i);
      r = int'(rd_sect);
      chk("R2 wr_en", 32'(wr_en), 32'(exp_we));
      chk("R9 status", 32'(rd_status), {30'd0, m_ld[r], m_blocked(r)});
      chk("R10 grant", 32'(pe_grant), 32'(pe_req && !m_blocked(int'(pe_sect))));
      chk("R10 err", 32'(prot_err), 32'(m_err));
    end
  end

  task automatic step(bit lk, bit ul, bit ld, int s);
    @(negedge clk);
    cmd_sect = W'(s); lock = lk; unlock = ul; ldown = ld;
    @(negedge clk);
    lock = 0; unlock = 0; ldown = 0;
    #1;
  endtask

  task automatic status(int s, logic [1:0] exp, string tag);
    rd_sect = W'(s);
    #0.1;
    chk(tag, 32'(rd_status), 32'(exp));
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) status(i, 2'b01, "R1 reset status");
    chk("R1 reset wr_en", 32'(wr_en), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    cmp_en = 1'b1;
    #1;
    for (int i = 0; i < N; i++) status(i, 2'b01, "R1 after release");

    // sector 3, pin low
    step(0, 1, 0, 3); status(3, 2'b00, "R4 unlock 001->000");
    chk("R2 writable in 000", 32'(wr_en[3]), 32'd1);
    step(1, 0, 0, 3); status(3, 2'b01, "R3 lock 000->001");
    step(0, 1, 0, 3); step(0, 0, 1, 3); status(3, 2'b11, "R5 lockdown ->011");
    chk("R2 blocked in 011", 32'(wr_en[3]), 32'd0);
    step(0, 1, 0, 3); status(3, 2'b11, "R6 unlock ignored in 011");
    step(1, 0, 0, 3); status(3, 2'b11, "R6 lock ignored in 011");
    step(0, 0, 1, 3); status(3, 2'b11, "R6 lockdown ignored in 011");
    // pin high
    @(negedge clk) wp = 1'b1; #1;
    step(0, 1, 0, 3); status(3, 2'b10, "R7 unlock 111->110");
    chk("R7 writable in 110", 32'(wr_en[3]), 32'd1);
    step(1, 0, 0, 3); status(3, 2'b11, "R7 lock 110->111");
    step(0, 1, 0, 3);
    @(negedge clk) wp = 1'b0; status(3, 2'b11, "R8 pin falls reads locked");
    @(negedge clk) wp = 1'b1; status(3, 2'b11, "R8 lock bit forced");
    // request to blocked sector
    @(negedge clk) pe_req = 1'b1; pe_sect = 3'd3; #1;
    chk("R10 refused grant", 32'(pe_grant), 32'd0);
    @(negedge clk) pe_req = 1'b0; #1;
    chk("R10 err pulse", 32'(prot_err), 32'd1);
    @(negedge clk) #1;
    chk("R10 err single cycle", 32'(prot_err), 32'd0);
    step(0, 1, 0, 3);
    @(negedge clk) pe_req = 1'b1; #1;
    chk("R10 granted", 32'(pe_grant), 32'd1);
    @(negedge clk) pe_req = 1'b0; #1;
    chk("R10 no err after grant", 32'(prot_err), 32'd0);
    // pin high, plain sector: 101->100->101, lockdown ->111
    step(0, 1, 0, 0); status(0, 2'b00, "R4 unlock 101->100");
    step(1, 0, 0, 0); status(0, 2'b01, "R3 lock 100->101");
    step(0, 0, 1, 0); status(0, 2'b11, "R5 lockdown ->111");
    // priority and isolation
    step(1, 1, 0, 4); status(4, 2'b01, "R11 lock over unlock");
    step(0, 1, 1, 5); status(5, 2'b11, "R11 lockdown over unlock");
    status(6, 2'b01, "R11 other sector untouched");
    step(0, 1, 0, 4); status(4, 2'b00, "R11 unlock alone");
    status(3, 2'b10, "R11 sector 3 untouched");

    // random phase
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (c == 3000) begin
        rst_n = 1'b0; #1;
        for (int i = 0; i < N; i++) status(i, 2'b01, "R1 mid-run reset");
        @(negedge clk) rst_n = 1'b1;
      end
      if ($urandom_range(15) == 0) wp = ~wp;
      cmd_sect = W'($urandom_range(N - 1));
      rd_sect  = W'($urandom_range(N - 1));
      pe_sect  = W'($urandom_range(N - 1));
      lock     = ($urandom_range(3) == 0);
      unlock   = ($urandom_range(2) == 0);
      ldown    = ($urandom_range(11) == 0);
      pe_req   = ($urandom_range(1) == 0);
    end
    @(negedge clk);
    lock = 0; unlock = 0; ldown = 0; pe_req = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule